// File: doc/BRIEF.md
# Predicated Instruction Execution Slot

This block is the combinational execute stage for one issue slot of an explicitly parallel processor. It receives one 15-bit instruction word and the two operand values that were read for it. It also receives the slot's current predicate bit and the byte on the board switches. From these it works out what the instruction should do and presents the result as a bundle of effect requests: a register write, a predicate update, a branch request and a display request. A later commit stage applies them. This block does not read registers, check hazards or hold any state.

The instruction fields have fixed positions. The opcode is in bits [14:11], the source register index in bits [10:7] and the destination register index in bits [6:3]. Bits [2:0] are unused. The load-immediate and branch instructions instead take an 8-bit value from bits [10:3]. The first register field only ever names a source. The second field names the destination, and the add and and operations also read it as their second operand. Every effect, including the zero test that rewrites the predicate, is produced only while the predicate input is 1. Any request output that is not asserted is held at zero.

Top module: `pred_exec_slot`

## Requirements
- R1: When `predIn` is 0, every output is 0, whatever the instruction.
- R2: With `predIn`=1, opcode 0001 (copy) writes `srcVal` to the register named by bits [6:3]. No other request is raised.
- R3: With `predIn`=1, opcode 0010 writes `srcVal + dstVal` modulo 256, and opcode 0011 writes `srcVal & dstVal`. Both write to the register named by bits [6:3].
- R4: With `predIn`=1, opcode 0100 writes bits [10:3] of the instruction to register 0, regardless of the register fields.
- R5: With `predIn`=1, opcode 0101 raises `jmpEn` with `jmpAddr` equal to bits [10:3]. It writes no register.
- R6: With `predIn`=1, opcode 1000 writes `~srcVal`. Opcode 1011 writes `srcVal` shifted right by one with a 0 entering bit 7. Opcode 1100 writes `srcVal` shifted left by one with a 0 entering bit 0. All three write to the register named by bits [6:3].
- R7: With `predIn`=1, opcode 1101 writes `srcVal` shifted right by one with bit 7 kept.
- R8: With `predIn`=1, opcode 1001 raises `outEn` with `outVal` equal to `srcVal`. It writes no register.
- R9: With `predIn`=1, opcode 1010 writes `dipIn` to the register named by bits [6:3].
- R10: With `predIn`=1, opcode 1111 raises `predWrEn` with `predWrVal` equal to 1 exactly when `srcVal` is 0. It writes no register.
- R11: Opcodes 0000, 0110, 0111 and 1110 produce all-zero outputs. Any one instruction raises at most one of `wrEn`, `predWrEn`, `jmpEn` and `outEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 15 | Instruction word |
| srcVal | input | 8 | Value of the register named by bits [10:7] |
| dstVal | input | 8 | Value of the register named by bits [6:3] |
| predIn | input | 1 | Current predicate bit |
| dipIn | input | 8 | Switch input byte |
| wrEn | output | 1 | Register write request |
| wrAddr | output | 4 | Register index to write |
| wrData | output | 8 | Data to write |
| predWrEn | output | 1 | Predicate update request |
| predWrVal | output | 1 | New predicate value |
| jmpEn | output | 1 | Branch request |
| jmpAddr | output | 8 | Instruction-line target |
| outEn | output | 1 | Display output request |
| outVal | output | 8 | Value to display |

## Verification
The in-line checks assume the inputs change only between evaluations and settle together, so the outputs they test always belong to one complete instruction. The bench applies each instruction and its operands at a single time point, well away from the sampling point. The bench sweeps every opcode with both predicate values. It also covers the operand corners: zero and nonzero operands for the zero test, a negative value for the arithmetic shift, and a carry out of the adder. Unused opcodes and nonzero register fields are included in the load-immediate case.

// File: rtl/slot_pkg.sv
package slot_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'b0000,
    OP_MOV = 4'b0001,
    OP_ADD = 4'b0010,
    OP_AND = 4'b0011,
    OP_LDI = 4'b0100,
    OP_JMP = 4'b0101,
    OP_INV = 4'b1000,
    OP_SHO = 4'b1001,
    OP_DIP = 4'b1010,
    OP_SRL = 4'b1011,
    OP_SLL = 4'b1100,
    OP_SRA = 4'b1101,
    OP_TSZ = 4'b1111
  } opcode_e;

  typedef enum logic [3:0] {
    SEL_SRC,
    SEL_SUM,
    SEL_AND,
    SEL_IMM,
    SEL_INV,
    SEL_DIP,
    SEL_SRL,
    SEL_SLL,
    SEL_SRA
  } dataSel_e;

  typedef struct packed {
    logic     wrEn;
    logic     dstZero;
    logic     predWrEn;
    logic     jmpEn;
    logic     outEn;
    dataSel_e dataSel;
  } slotCtl_t;

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             predIn,
  output slotCtl_t         ctl
);

  slotCtl_t raw;

  always_comb begin
    raw = '0;
    raw.dataSel = SEL_SRC;
    case (opcode_e'(opcode))
      OP_MOV: begin raw.wrEn = 1'b1; raw.dataSel = SEL_SRC; end
      OP_ADD: begin raw.wrEn = 1'b1; raw.dataSel = SEL_SUM; end
      OP_AND: begin raw.wrEn = 1'b1; raw.dataSel = SEL_AND; end
      OP_LDI: begin raw.wrEn = 1'b1; raw.dstZero = 1'b1; raw.dataSel = SEL_IMM; end
      OP_INV: begin raw.wrEn = 1'b1; raw.dataSel = SEL_INV; end
      OP_DIP: begin raw.wrEn = 1'b1; raw.dataSel = SEL_DIP; end
      OP_SRL: begin raw.wrEn = 1'b1; raw.dataSel = SEL_SRL; end
      OP_SLL: begin raw.wrEn = 1'b1; raw.dataSel = SEL_SLL; end
      OP_SRA: begin raw.wrEn = 1'b1; raw.dataSel = SEL_SRA; end
      OP_JMP: raw.jmpEn    = 1'b1;
      OP_SHO: raw.outEn    = 1'b1;
      OP_TSZ: raw.predWrEn = 1'b1;
      default: raw = '0;
    endcase
  end

  // every strobe is qualified by the predicate
  always_comb begin
    ctl = raw;
    if (!predIn) begin
      ctl.wrEn     = 1'b0;
      ctl.predWrEn = 1'b0;
      ctl.jmpEn    = 1'b0;
      ctl.outEn    = 1'b0;
    end
  end

  // R11
  always_comb begin
    one_effect_chk: assert ($onehot0({ctl.wrEn, ctl.predWrEn, ctl.jmpEn, ctl.outEn}))
      else $error("more than one effect strobe");
  end

endmodule

// File: rtl/slot_dp.sv
module slot_dp
  import slot_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_IDX_W = 4
) (
  input  slotCtl_t             ctl,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic [DATA_W-1:0]    dstVal,
  input  logic [DATA_W-1:0]    immVal,
  input  logic [DATA_W-1:0]    dipIn,
  input  logic [REG_IDX_W-1:0] dstIdx,
  output logic                 wrEn,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic                 predWrEn,
  output logic                 predWrVal,
  output logic                 jmpEn,
  output logic [DATA_W-1:0]    jmpAddr,
  output logic                 outEn,
  output logic [DATA_W-1:0]    outVal
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0]    result;
  logic [REG_IDX_W-1:0] addrSel;
  logic                 srcZero;

  always_comb begin
    case (ctl.dataSel)
      SEL_SUM: result = srcVal + dstVal;
      SEL_AND: result = srcVal & dstVal;
      SEL_IMM: result = immVal;
      SEL_INV: result = ~srcVal;
      SEL_DIP: result = dipIn;
      SEL_SRL: result = {1'b0, srcVal[MSB:1]};
      SEL_SLL: result = {srcVal[MSB-1:0], 1'b0};
      SEL_SRA: result = {srcVal[MSB], srcVal[MSB:1]};
      default: result = srcVal;
    endcase
  end

  assign addrSel = ctl.dstZero ? '0 : dstIdx;
  assign srcZero = (srcVal == '0);

  assign wrEn      = ctl.wrEn;
  assign wrAddr    = ctl.wrEn ? addrSel : '0;
  assign wrData    = ctl.wrEn ? result : '0;
  assign predWrEn  = ctl.predWrEn;
  assign predWrVal = ctl.predWrEn & srcZero;
  assign jmpEn     = ctl.jmpEn;
  assign jmpAddr   = ctl.jmpEn ? immVal : '0;
  assign outEn     = ctl.outEn;
  assign outVal    = ctl.outEn ? srcVal : '0;

  // R11
  always_comb begin
    idle_zero_chk: assert (wrEn || (wrAddr == '0 && wrData == '0))
      else $error("write bundle not zero while idle");
  end

endmodule

// File: rtl/pred_exec_slot.sv
module pred_exec_slot
  import slot_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_IDX_W = 4,
  parameter int OPC_W     = 4,
  parameter int INSTR_W   = 15
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic [DATA_W-1:0]    dstVal,
  input  logic                 predIn,
  input  logic [DATA_W-1:0]    dipIn,
  output logic                 wrEn,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic                 predWrEn,
  output logic                 predWrVal,
  output logic                 jmpEn,
  output logic [DATA_W-1:0]    jmpAddr,
  output logic                 outEn,
  output logic [DATA_W-1:0]    outVal
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int SRC_LSB = OPC_LSB - REG_IDX_W;
  localparam int DST_LSB = SRC_LSB - REG_IDX_W;
  localparam int IMM_LSB = DST_LSB;

  logic [OPC_W-1:0]     opcode;
  logic [REG_IDX_W-1:0] dstIdx;
  logic [DATA_W-1:0]    immVal;
  slotCtl_t             ctl;

  assign opcode = instr[INSTR_W-1:OPC_LSB];
  assign dstIdx = instr[DST_LSB +: REG_IDX_W];
  assign immVal = instr[IMM_LSB +: DATA_W];

  slot_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .opcode (opcode),
    .predIn (predIn),
    .ctl    (ctl)
  );

  slot_dp #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_dp (
    .ctl       (ctl),
    .srcVal    (srcVal),
    .dstVal    (dstVal),
    .immVal    (immVal),
    .dipIn     (dipIn),
    .dstIdx    (dstIdx),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .predWrEn  (predWrEn),
    .predWrVal (predWrVal),
    .jmpEn     (jmpEn),
    .jmpAddr   (jmpAddr),
    .outEn     (outEn),
    .outVal    (outVal)
  );

  // R1
  always_comb begin
    pred_gate_chk: assert (predIn || !(wrEn || predWrEn || jmpEn || outEn))
      else $error("effect raised with predicate clear");
  end

  // R4
  always_comb begin
    ldi_reg0_chk: assert (!(wrEn && opcode == OP_LDI) || wrAddr == '0)
      else $error("immediate load not aimed at register 0");
  end

  // R7
  always_comb begin
    sra_sign_chk: assert (!(wrEn && opcode == OP_SRA) || wrData[DATA_W-1] == srcVal[DATA_W-1])
      else $error("arithmetic shift lost the sign");
  end

  // R2
  always_comb begin
    dst_field_chk: assert (!(wrEn && opcode != OP_LDI) || wrAddr == dstIdx)
      else $error("write not aimed at destination field");
  end

endmodule

// File: tb/pred_exec_slot_test.sv
module pred_exec_slot_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic [3:0] op;
    logic [35:0] bundle;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [14:0] instr = '0;
  logic [7:0]  srcVal = '0, dstVal = '0, dipIn = '0;
  logic        predIn = 1'b0;
  logic        wrEn, predWrEn, predWrVal, jmpEn, outEn;
  logic [3:0]  wrAddr;
  logic [7:0]  wrData, jmpAddr, outVal;

  int errors = 0;
  int checks = 0;
  bit driveDone = 1'b0;
  expItem_t sbQ[$];

  pred_exec_slot uut (
    .instr(instr), .srcVal(srcVal), .dstVal(dstVal), .predIn(predIn), .dipIn(dipIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .predWrEn(predWrEn),
    .predWrVal(predWrVal), .jmpEn(jmpEn), .jmpAddr(jmpAddr), .outEn(outEn), .outVal(outVal)
  );

  function automatic logic [35:0] pack(input logic we, input logic [3:0] wa, input logic [7:0] wd,
                                       input logic pe, input logic pv, input logic je,
                                       input logic [7:0] ja, input logic oe, input logic [7:0] ov);
    return {we, wa, wd, pe, pv, je, ja, oe, ov};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [3:0] r1, input logic [3:0] r2,
                       input logic [7:0] s, input logic [7:0] d, input logic p, input logic [7:0] dip);
    expItem_t it;
    logic [7:0] imm;
    imm = {r1, r2};
    it.op = op;
    it.bundle = '0;
    case (op)
      4'b0001: begin it.tag = "R2";  it.bundle = pack(1, r2, s, 0, 0, 0, 0, 0, 0); end
      4'b0010: begin it.tag = "R3";  it.bundle = pack(1, r2, 8'(s + d), 0, 0, 0, 0, 0, 0); end
      4'b0011: begin it.tag = "R3";  it.bundle = pack(1, r2, s & d, 0, 0, 0, 0, 0, 0); end
      4'b0100: begin it.tag = "R4";  it.bundle = pack(1, 0, imm, 0, 0, 0, 0, 0, 0); end
      4'b0101: begin it.tag = "R5";  it.bundle = pack(0, 0, 0, 0, 0, 1, imm, 0, 0); end
      4'b1000: begin it.tag = "R6";  it.bundle = pack(1, r2, ~s, 0, 0, 0, 0, 0, 0); end
      4'b1001: begin it.tag = "R8";  it.bundle = pack(0, 0, 0, 0, 0, 0, 0, 1, s); end
      4'b1010: begin it.tag = "R9";  it.bundle = pack(1, r2, dip, 0, 0, 0, 0, 0, 0); end
      4'b1011: begin it.tag = "R6";  it.bundle = pack(1, r2, s >> 1, 0, 0, 0, 0, 0, 0); end
      4'b1100: begin it.tag = "R6";  it.bundle = pack(1, r2, 8'(s << 1), 0, 0, 0, 0, 0, 0); end
      4'b1101: begin it.tag = "R7";  it.bundle = pack(1, r2, {s[7], s[7:1]}, 0, 0, 0, 0, 0, 0); end
      4'b1111: begin it.tag = "R10"; it.bundle = pack(0, 0, 0, 1, s == 0, 0, 0, 0, 0); end
      default: it.tag = "R11";
    endcase
    if (!p) begin
      it.tag = "R1";
      it.bundle = '0;
    end
    @(posedge clk);
    #1;
    instr  = {op, r1, r2, 3'b101};
    srcVal = s;
    dstVal = d;
    predIn = p;
    dipIn  = dip;
    sbQ.push_back(it);
  endtask

  // monitor: compares at the falling edge, away from input changes
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        expItem_t it;
        logic [35:0] act;
        it = sbQ.pop_front();
        act = {wrEn, wrAddr, wrData, predWrEn, predWrVal, jmpEn, jmpAddr, outEn, outVal};
        checks++;
        if (act !== it.bundle) begin
          errors++;
          $display("FAIL %s op=%b actual=%h expected=%h", it.tag, it.op, act, it.bundle);
        end
        if (it.tag != "R1" && it.tag != "R11" && it.tag != "R5" && it.tag != "R8" && it.tag != "R10") begin
          // R11 at most one request per instruction
          checks++;
          if ($countones({wrEn, predWrEn, jmpEn, outEn}) != 1) begin
            errors++;
            $display("FAIL R11 strobes actual=%0d expected=1",
                     $countones({wrEn, predWrEn, jmpEn, outEn}));
          end
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state: idle inputs give no effect
    checks++;
    if ({wrEn, predWrEn, jmpEn, outEn} !== 4'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%b expected=0000", {wrEn, predWrEn, jmpEn, outEn});
    end
    apply(4'b0001, 4'h3, 4'h9, 8'h5A, 8'h11, 1, 8'h00);  // R2
    apply(4'b0010, 4'h1, 4'h2, 8'hF0, 8'h25, 1, 8'h00);  // R3 carry out
    apply(4'b0011, 4'h1, 4'hE, 8'hCC, 8'hAA, 1, 8'h00);  // R3
    apply(4'b0100, 4'hA, 4'h7, 8'h12, 8'h34, 1, 8'h00);  // R4
    apply(4'b0101, 4'h4, 4'hC, 8'h00, 8'h00, 1, 8'h00);  // R5
    apply(4'b1000, 4'h2, 4'h5, 8'h3C, 8'h00, 1, 8'h00);  // R6
    apply(4'b1011, 4'h2, 4'h5, 8'h81, 8'h00, 1, 8'h00);  // R6
    apply(4'b1100, 4'h2, 4'h5, 8'h81, 8'h00, 1, 8'h00);  // R6
    apply(4'b1101, 4'h2, 4'h5, 8'h82, 8'h00, 1, 8'h00);  // R7 negative
    apply(4'b1101, 4'h2, 4'h5, 8'h43, 8'h00, 1, 8'h00);  // R7 positive
    apply(4'b1001, 4'h6, 4'h1, 8'h9D, 8'h00, 1, 8'h00);  // R8
    apply(4'b1010, 4'h6, 4'hB, 8'h00, 8'h00, 1, 8'hE7);  // R9
    apply(4'b1111, 4'h6, 4'h1, 8'h00, 8'h00, 1, 8'h00);  // R10 zero
    apply(4'b1111, 4'h6, 4'h1, 8'h40, 8'h00, 1, 8'h00);  // R10 nonzero
    apply(4'b0000, 4'hF, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);  // R11
    apply(4'b0110, 4'hF, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);  // R11
    apply(4'b0111, 4'hF, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);  // R11
    apply(4'b1110, 4'hF, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);  // R11
    // R1 every opcode with predicate clear
    for (int op = 0; op < 16; op++)
      apply(4'(op), 4'h5, 4'h9, 8'h00, 8'h77, 0, 8'h3A);
    // mixed sweep with both predicate values
    for (int k = 0; k < 64; k++)
      apply(4'(k * 7), 4'(k * 3), 4'(k * 5 + 1), 8'(k * 37), 8'(k * 91 + 13), k % 5 != 0, 8'(k * 29));
    repeat (3) @(posedge clk);
    driveDone = 1'b1;
  end

  initial begin
    fork
      wait (driveDone && sbQ.size() == 0);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule